// File: doc/BRIEF.md
# Serial Frame Engine with Timed Break

This block turns bytes into asynchronous serial frames and recovers bytes from an incoming serial line. It has no baud generator of its own: every bit lasts a fixed number of `os_tick` strobes (13 by default), and the strobe is supplied by a shared rate divider. A 10-bit line-control word sets the frame format at run time. It selects 7 or 8 data bits, one or two stop bits, and parity that can be off, even or odd. The same word can route the transmitter straight into the receiver for self-test.

Each received character is returned as a 10-bit word. The data sits in the low byte, and the parity and framing error flags are packed above it, so one handshake carries the character and its quality. The transmitter can also hold the line low for a programmed number of bit periods. When that break ends, it raises a one-cycle completion pulse. A four-bit status vector shows what the transmitter and receiver are doing.

Top module: `uart_frame_engine`

## Requirements
- R1: After reset, `txd` is 1, `rx_valid` is 0, `status` is 0 and `brk_done` is 0.
- R2: A frame starts with a low start bit, then sends the data least significant bit first: 7 bits when `lcr[2]`=0 and 8 bits when `lcr[2]`=1. An optional parity bit follows, then one stop bit (`lcr[3]`=0) or two stop bits (`lcr[3]`=1) at level 1. Every bit lasts OSR ticks.
- R3: `tx_ready` is 1 only when `lcr[0]` is 1 and the transmitter is idle with no break running or pending. After a byte is accepted, `status[1]` is 1 until the next tick starts the frame. `status[0]` is 1 for the whole frame, including the last stop bit.
- R4: When `lcr[4]`=1, a parity bit is sent. It makes the count of ones over the selected data bits and the parity bit even when `lcr[5]`=0 and odd when `lcr[5]`=1. Data bit 7 takes no part in 7-bit mode.
- R5: The receiver confirms a start bit at sample MID (6 of 13) after it sees the line low, then samples each bit at its midpoint. `rx_word[7:0]` holds the data; in 7-bit mode `rx_word[7]` is 0.
- R6: With parity enabled, `rx_word[8]` is 1 exactly when the received parity bit does not match the mode in `lcr[5]`.
- R7: `rx_word[9]` is 1 when the first stop bit is sampled low.
- R8: `rx_valid` (`status[3]`) stays high with `rx_word` unchanged until `rx_ready` is high for one cycle, and falls on the next cycle. When `lcr[1]`=0, the receiver ignores the line: no word appears and `status[2]` stays 0.
- R9: With `lcr[7]`=1, the serial output drives the receiver internally, `rxd` is ignored, and `txd` stays 1.
- R10: A rising edge on `lcr[9]` starts a break once the transmitter is idle. The line is held low for `brk_len` bit periods, then returns high, and `brk_done` pulses for one cycle. A count of 0 gives the pulse without any low time.
- R11: A low pulse on the line that is shorter than MID ticks produces no character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | Oversampling strobe, OSR per bit |
| lcr | input | 10 | Line control: 0 tx en, 1 rx en, 2 8-bit, 3 two stop, 4 parity en, 5 odd, 7 loopback, 9 break request |
| brk_len | input | BRK_W | Break length in bit periods |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | Byte offered |
| tx_ready | output | 1 | Byte accepted this cycle when valid |
| rx_word | output | 10 | {frame error, parity error, data} |
| rx_valid | output | 1 | Received word available |
| rx_ready | input | 1 | Consumer takes the word |
| txd | output | 1 | Serial output, idle high |
| rxd | input | 1 | Serial input |
| status | output | 4 | {rx ready, rx active, tx loading, tx active} |
| brk_done | output | 1 | One-cycle pulse at break end |

## Verification
On every cycle, the assertions check these properties:
- the transmit line stays high whenever nothing is being sent;
- loopback keeps the pin idle;
- `tx_ready` never coincides with a loading or active transmitter;
- a held receive word stays stable until it is taken;
- a 7-bit character never carries bit 7;
- the line is low throughout a break, and the break-done event is a single pulse.

Only the bench scenarios can show the rest. These are the bit order and parity value of each frame format, the stop-bit count, the error flags on deliberately corrupted frames, rejection of a short glitch, and the measured break length.

// File: rtl/uart_fe_pkg.sv
package uart_fe_pkg;

  typedef struct packed {
    logic brk;
    logic loopb;
    logic podd;
    logic pen;
    logic stop2;
    logic len8;
    logic rxen;
    logic txen;
  } lcfg_t;

  // parity over the selected data bits, inverted for odd mode
  function automatic logic par_bit(input logic [7:0] d, input logic len8, input logic odd);
    return (^{d[7] & len8, d[6:0]}) ^ odd;
  endfunction

  // total bits in a frame: start + 7 data + stop, plus the optional ones
  function automatic logic [3:0] frame_bits(input logic len8, input logic pen, input logic stop2);
    return 4'd9 + {3'b0, len8} + {3'b0, pen} + {3'b0, stop2};
  endfunction

endpackage

// File: rtl/uart_fe_tx.sv
module uart_fe_tx
  import uart_fe_pkg::*;
#(
  parameter int OSR = 13
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  lcfg_t      cfg,
  input  logic       hold,
  input  logic [7:0] data,
  input  logic       valid,
  output logic       ready,
  output logic       line,
  output logic       idle,
  output logic       sending,
  output logic       loading
);
  localparam int CW = $clog2(OSR);

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_SEND} st_t;

  st_t         st;
  logic [CW-1:0] cnt;
  logic [11:0] sh;
  logic [3:0]  idx;
  logic [3:0]  last;
  logic [11:0] frame;

  always_comb begin
    frame    = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < 7; i++) frame[1+i] = data[i];
    if (cfg.len8) frame[8] = data[7];
    if (cfg.pen) begin
      if (cfg.len8) frame[9] = par_bit(data, 1'b1, cfg.podd);
      else          frame[8] = par_bit(data, 1'b0, cfg.podd);
    end
  end

  assign ready   = cfg.txen && (st == S_IDLE) && !hold;
  assign idle    = (st == S_IDLE);
  assign sending = (st == S_SEND);
  assign loading = (st == S_LOAD);
  assign line    = (st == S_SEND) ? sh[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      cnt  <= '0;
      sh   <= '1;
      idx  <= '0;
      last <= '0;
    end else begin
      unique case (st)
        S_IDLE: if (valid && ready) begin
          sh   <= frame;
          last <= frame_bits(cfg.len8, cfg.pen, cfg.stop2) - 4'd1;
          st   <= S_LOAD;
        end
        S_LOAD: if (tick) begin
          st  <= S_SEND;
          cnt <= '0;
          idx <= '0;
        end
        S_SEND: if (tick) begin
          if (cnt == CW'(OSR - 1)) begin
            cnt <= '0;
            sh  <= {1'b1, sh[11:1]};
            if (idx == last) st <= S_IDLE;
            else             idx <= idx + 4'd1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_fe_rx.sv
module uart_fe_rx
  import uart_fe_pkg::*;
#(
  parameter int OSR = 13,
  parameter int MID = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  lcfg_t      cfg,
  input  logic       line,
  input  logic       ready,
  output logic [9:0] word,
  output logic       valid,
  output logic       busy,
  output logic       done
);
  localparam int CW = $clog2(OSR);

  typedef enum logic [2:0] {R_IDLE, R_START, R_DATA, R_PAR, R_STOP} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [2:0]    bitn;
  logic [7:0]    sh;
  logic          pbit;
  logic          mid_hit;
  logic [7:0]    dat;
  logic          perr;

  assign mid_hit = tick && (cnt == CW'(OSR - 1));
  assign dat     = cfg.len8 ? sh : {1'b0, sh[7:1]};
  assign perr    = cfg.pen && (par_bit(dat, cfg.len8, cfg.podd) != pbit);
  assign busy    = (st != R_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= R_IDLE;
      cnt   <= '0;
      bitn  <= '0;
      sh    <= '0;
      pbit  <= 1'b0;
      word  <= '0;
      valid <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (ready) valid <= 1'b0;
      if (!cfg.rxen) begin
        st <= R_IDLE;
      end else begin
        unique case (st)
          R_IDLE: if (tick && !line) begin
            st  <= R_START;
            cnt <= '0;
          end
          R_START: if (tick) begin
            if (cnt == CW'(MID - 1)) begin
              st   <= line ? R_IDLE : R_DATA;
              cnt  <= '0;
              bitn <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          R_DATA: if (tick) begin
            if (mid_hit) begin
              cnt  <= '0;
              sh   <= {line, sh[7:1]};
              bitn <= bitn + 3'd1;
              if (bitn == (cfg.len8 ? 3'd7 : 3'd6))
                st <= cfg.pen ? R_PAR : R_STOP;
            end else cnt <= cnt + 1'b1;
          end
          R_PAR: if (tick) begin
            if (mid_hit) begin
              cnt  <= '0;
              pbit <= line;
              st   <= R_STOP;
            end else cnt <= cnt + 1'b1;
          end
          R_STOP: if (tick) begin
            if (mid_hit) begin
              cnt   <= '0;
              word  <= {!line, perr, dat};
              valid <= 1'b1;
              done  <= 1'b1;
              st    <= R_IDLE;
            end else cnt <= cnt + 1'b1;
          end
          default: st <= R_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_fe_brk.sv
module uart_fe_brk #(
  parameter int OSR   = 13,
  parameter int BRK_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             start,
  input  logic [BRK_W-1:0] count,
  output logic             active,
  output logic             done
);
  localparam int CW = $clog2(OSR);

  logic [BRK_W-1:0] rem;
  logic [CW-1:0]    cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      done   <= 1'b0;
      rem    <= '0;
      cnt    <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        if (count == '0) begin
          done <= 1'b1;
        end else begin
          active <= 1'b1;
          rem    <= count;
          cnt    <= '0;
        end
      end else if (active && tick) begin
        if (cnt == CW'(OSR - 1)) begin
          cnt <= '0;
          if (rem == BRK_W'(1)) begin
            active <= 1'b0;
            done   <= 1'b1;
          end else begin
            rem <= rem - 1'b1;
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/uart_frame_engine.sv
module uart_frame_engine
  import uart_fe_pkg::*;
#(
  parameter int OSR   = 13,
  parameter int MID   = 6,
  parameter int BRK_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             os_tick,
  input  logic [9:0]       lcr,
  input  logic [BRK_W-1:0] brk_len,
  input  logic [7:0]       tx_data,
  input  logic             tx_valid,
  output logic             tx_ready,
  output logic [9:0]       rx_word,
  output logic             rx_valid,
  input  logic             rx_ready,
  output logic             txd,
  input  logic             rxd,
  output logic [3:0]       status,
  output logic             brk_done
);
  lcfg_t cfg;
  logic  unused_lc;
  logic  rxd_m, rxd_s;
  logic  tx_line, ser_line, rx_in;
  logic  tx_idle, tx_sending, tx_loading;
  logic  brk_active, brk_pend, brk_req_q, brk_start;
  logic  rx_busy, rx_done;

  assign cfg.txen  = lcr[0];
  assign cfg.rxen  = lcr[1];
  assign cfg.len8  = lcr[2];
  assign cfg.stop2 = lcr[3];
  assign cfg.pen   = lcr[4];
  assign cfg.podd  = lcr[5];
  assign cfg.loopb = lcr[7];
  assign cfg.brk   = lcr[9];
  assign unused_lc = ^{lcr[8], lcr[6]};

  // two-stage synchronizer on the external line
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxd_m <= 1'b1;
      rxd_s <= 1'b1;
    end else begin
      rxd_m <= rxd;
      rxd_s <= rxd_m;
    end
  end

  // break request: edge detect, held until the transmitter is idle
  assign brk_start = brk_pend && tx_idle && !brk_active;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      brk_req_q <= 1'b0;
      brk_pend  <= 1'b0;
    end else begin
      brk_req_q <= cfg.brk;
      if (brk_start)                  brk_pend <= 1'b0;
      else if (cfg.brk && !brk_req_q) brk_pend <= 1'b1;
    end
  end

  uart_fe_tx #(.OSR(OSR)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(os_tick), .cfg(cfg),
    .hold(brk_active | brk_pend), .data(tx_data), .valid(tx_valid),
    .ready(tx_ready), .line(tx_line), .idle(tx_idle),
    .sending(tx_sending), .loading(tx_loading)
  );

  uart_fe_brk #(.OSR(OSR), .BRK_W(BRK_W)) u_brk (
    .clk(clk), .rst_n(rst_n), .tick(os_tick), .start(brk_start),
    .count(brk_len), .active(brk_active), .done(brk_done)
  );

  assign ser_line = tx_line & ~brk_active;
  assign rx_in    = cfg.loopb ? ser_line : rxd_s;
  assign txd      = cfg.loopb ? 1'b1 : ser_line;

  uart_fe_rx #(.OSR(OSR), .MID(MID)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(os_tick), .cfg(cfg), .line(rx_in),
    .ready(rx_ready), .word(rx_word), .valid(rx_valid),
    .busy(rx_busy), .done(rx_done)
  );

  assign status = {rx_valid, rx_busy, tx_loading, tx_sending | brk_active};
endmodule

// File: rtl/uart_fe_chk.sv
module uart_fe_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [9:0] lcr,
  input logic       tx_ready,
  input logic       txd,
  input logic [3:0] status,
  input logic [9:0] rx_word,
  input logic       rx_valid,
  input logic       rx_ready,
  input logic       brk_done,
  input logic       brk_active,
  input logic       rx_done
);
  // R2
  tx_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !status[0] |-> txd);

  // R9
  loop_pin_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lcr[7] |-> txd);

  // R3
  ready_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> (!status[0] && !status[1] && lcr[0]));

  // R5
  len7_msb_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && !lcr[2]) |-> !rx_word[7]);

  // R8
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && ($stable(rx_word) || rx_done)));

  // R10
  brk_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_done |=> !brk_done);

  // R10
  brk_line_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_active && !lcr[7]) |-> !txd);
endmodule

bind uart_frame_engine uart_fe_chk u_chk (
  .clk(clk), .rst_n(rst_n), .lcr(lcr), .tx_ready(tx_ready), .txd(txd),
  .status(status), .rx_word(rx_word), .rx_valid(rx_valid),
  .rx_ready(rx_ready), .brk_done(brk_done), .brk_active(brk_active),
  .rx_done(rx_done)
);

// File: tb/sim_uart_frame_engine.sv
module sim_uart_frame_engine;
  localparam int CLK_P    = 10;
  localparam int TICK_DIV = 2;
  localparam int BITC     = 13 * TICK_DIV;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        os_tick = 1'b0;
  logic [9:0]  lcr = '0;
  logic [11:0] brk_len = '0;
  logic [7:0]  tx_data = '0;
  logic        tx_valid = 1'b0;
  logic        tx_ready;
  logic [9:0]  rx_word;
  logic        rx_valid;
  logic        rx_ready = 1'b0;
  logic        txd;
  logic        rxd = 1'b1;
  logic [3:0]  status;
  logic        brk_done;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int tdiv = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  always @(negedge clk) begin
    tdiv    <= (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
    os_tick <= (tdiv == TICK_DIV - 1);
  end

  uart_frame_engine u0 (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .lcr(lcr), .brk_len(brk_len),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_word(rx_word), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .txd(txd), .rxd(rxd), .status(status), .brk_done(brk_done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // expected line bits, index 0 = start bit
  function automatic logic [11:0] mk_frame(input logic [7:0] d, input bit len8, input bit pen,
      input bit odd, input bit stop2, input bit bad_par, input bit bad_stop, output int nb);
    logic [11:0] f;
    int pos;
    int ones;
    f = '1; f[0] = 1'b0; pos = 1; ones = 0;
    for (int i = 0; i < (len8 ? 8 : 7); i++) begin
      f[pos] = d[i]; ones += d[i]; pos++;
    end
    if (pen) begin
      f[pos] = ((ones % 2) == 1) ^ odd ^ bad_par;
      pos++;
    end
    if (bad_stop) f[pos] = 1'b0;
    nb = pos + 1 + (stop2 ? 1 : 0);
    return f;
  endfunction

  task automatic send_tx(input logic [7:0] d, input string req);
    logic [11:0] exp, got;
    int nb;
    bit last_busy;
    exp = mk_frame(d, lcr[2], lcr[4], lcr[5], lcr[3], 0, 0, nb);
    got = '1;
    tx_data = d; tx_valid = 1'b1;
    for (int i = 0; i < 100 && !tx_ready; i++) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
    chk(status[1] == 1'b1, "R3", "loading flag after accept", status, 4'h2);
    for (int i = 0; i < 100 && txd; i++) @(negedge clk);
    repeat (BITC/2) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      got[i] = txd;
      if (i == nb - 1) last_busy = status[0];
      repeat (BITC) @(negedge clk);
    end
    chk(got == exp, req, "tx frame bits", got, exp);
    chk(last_busy, "R3", "active in last stop bit", last_busy, 1);
    for (int i = 0; i < 100 && !tx_ready; i++) @(negedge clk);
  endtask

  task automatic drive_rx(input logic [11:0] f, input int nb);
    for (int i = 0; i < nb; i++) begin
      rxd = f[i];
      repeat (BITC) @(negedge clk);
    end
    rxd = 1'b1;
  endtask

  task automatic expect_rx(input logic [9:0] exp, input string req);
    for (int i = 0; i < 4*BITC && !rx_valid; i++) @(negedge clk);
    chk(rx_valid, req, "word valid", rx_valid, 1);
    chk(rx_word == exp, req, "rx word", rx_word, exp);
    repeat (20) @(negedge clk);
    chk(rx_valid && rx_word == exp, "R8", "word held until taken", rx_word, exp);
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
    chk(!rx_valid, "R8", "valid falls after take", rx_valid, 0);
  endtask

  task automatic rx_case(input logic [7:0] d, input bit bad_par, input bit bad_stop,
                         input logic [9:0] exp, input string req);
    logic [11:0] f;
    int nb;
    f = mk_frame(d, lcr[2], lcr[4], lcr[5], lcr[3], bad_par, bad_stop, nb);
    drive_rx(f, nb);
    expect_rx(exp, req);
  endtask

  task automatic test_reset;
    chk(txd == 1'b1, "R1", "txd idle", txd, 1);
    chk(rx_valid == 1'b0, "R1", "rx_valid", rx_valid, 0);
    chk(status == 4'h0, "R1", "status", status, 0);
    chk(brk_done == 1'b0, "R1", "brk_done", brk_done, 0);
    chk(tx_ready == 1'b0, "R3", "ready while disabled", tx_ready, 0);
    lcr = 10'h007;
    @(negedge clk);
    chk(tx_ready == 1'b1, "R3", "ready when enabled", tx_ready, 1);
  endtask

  task automatic test_tx;
    lcr = 10'h007; send_tx(8'hA5, "R2");
    lcr = 10'h01B; send_tx(8'hB5, "R4");
    lcr = 10'h037; send_tx(8'h0F, "R4");
  endtask

  task automatic test_rx;
    lcr = 10'h007; rx_case(8'h3C, 0, 0, 10'h03C, "R5");
    lcr = 10'h003; rx_case(8'hD5, 0, 0, 10'h055, "R5");
    lcr = 10'h037; rx_case(8'h6E, 0, 0, 10'h06E, "R6");
    lcr = 10'h017; rx_case(8'h81, 1, 0, 10'h181, "R6");
    lcr = 10'h007; rx_case(8'h42, 0, 1, 10'h242, "R7");
    repeat (BITC*12) @(negedge clk);
    rx_ready = 1'b1; @(negedge clk); rx_ready = 1'b0;
  endtask

  task automatic test_glitch;
    lcr = 10'h007;
    rxd = 1'b0;
    repeat (4) @(negedge clk);
    rxd = 1'b1;
    repeat (BITC*12) @(negedge clk);
    chk(!rx_valid, "R11", "no char from glitch", rx_valid, 0);
    chk(status[2] == 1'b0, "R11", "receiver idle after glitch", status[2], 0);
  endtask

  task automatic test_rx_off;
    logic [11:0] f;
    int nb;
    lcr = 10'h005;
    f = mk_frame(8'h5A, 1, 0, 0, 0, 0, 0, nb);
    drive_rx(f, nb);
    repeat (BITC) @(negedge clk);
    chk(!rx_valid, "R8", "disabled receiver gives no word", rx_valid, 0);
    chk(status[2] == 1'b0, "R8", "disabled receiver inactive", status[2], 0);
  endtask

  task automatic test_loop;
    bit low_seen;
    bit got;
    logic [9:0] w;
    low_seen = 0; got = 0; w = '0;
    lcr = 10'h087;
    tx_data = 8'h96; tx_valid = 1'b1;
    for (int i = 0; i < 100 && !tx_ready; i++) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
    for (int i = 0; i < 14*BITC; i++) begin
      if (!txd) low_seen = 1;
      if (rx_valid && !got) begin got = 1; w = rx_word; end
      @(negedge clk);
    end
    chk(!low_seen, "R9", "pin idle in loopback", low_seen, 0);
    chk(got && w == 10'h096, "R9", "looped word", w, 10'h096);
    rx_ready = 1'b1; @(negedge clk); rx_ready = 1'b0;
    lcr = 10'h007;
    @(negedge clk);
  endtask

  task automatic test_break;
    int lows;
    bit rdy_seen;
    bit done_at_end;
    lows = 0; rdy_seen = 0;
    brk_len = 12'd3;
    lcr = 10'h201;
    for (int i = 0; i < 20 && txd; i++) @(negedge clk);
    while (!txd && lows < 500) begin
      if (tx_ready) rdy_seen = 1;
      lows++;
      @(negedge clk);
    end
    done_at_end = brk_done;
    chk(lows >= 76 && lows <= 79, "R10", "break low cycles", lows, 78);
    chk(!rdy_seen, "R3", "no ready during break", rdy_seen, 0);
    chk(done_at_end, "R10", "done pulse at break end", done_at_end, 1);
    @(negedge clk);
    chk(!brk_done, "R10", "done is one cycle", brk_done, 0);
    lcr = 10'h001; brk_len = 12'd0;
    repeat (3) @(negedge clk);
    lcr = 10'h201;
    lows = 0; done_at_end = 0;
    for (int i = 0; i < 10; i++) begin
      if (!txd) lows++;
      if (brk_done) done_at_end = 1;
      @(negedge clk);
    end
    chk(done_at_end, "R10", "zero-length break done", done_at_end, 1);
    chk(lows == 0, "R10", "zero-length break no low", lows, 0);
    lcr = 10'h001;
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=%0d expected=done", cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_tx();
    test_rx();
    test_glitch();
    test_rx_off();
    test_loop();
    test_break();
    if (!finished) begin
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule